// File: doc/BRIEF.md
# Board Control Status and Parity Capture

This block holds the control/status word and the RAM parity fault registers of a network interface board. Software writes the control word to pulse the controller chip's reset and attention lines, to take the link out of loopback, to enable the auxiliary bus, and to enable two interrupt sources. It reads the same word back to see the RAM size strap, the upper RAM base strap and two live flags: a pending parity fault and a pending controller interrupt. The two interrupt sources combine into one board interrupt.

When the RAM parity checker reports an error, the block records the 20-bit failing address, the error source and the failing byte end in two registers. It holds them until software writes the acknowledge bit. A small two-state machine governs the capture. In `CAP_IDLE` (flag clear) an error strobe moves it to `CAP_HELD` and loads the details. In `CAP_HELD` an acknowledge returns it to `CAP_IDLE` and clears the details. Any other input leaves the state unchanged, and further strobes in `CAP_HELD` are dropped.

The host port selects one 16-bit register with `reg_sel`. Writes commit on the rising clock edge while `wr_en` is high. `rdata` is a combinational view of the selected register.

Top module: `bcs_board_ctl`

## Requirements
- R1: After reset every writable control bit, the fault flag, the captured address and the captured source/end flags are 0. `ctrl_reset`, `ctrl_attn`, `link_live`, `p2_enable` and `board_irq` are all low.
- R2: A write with `reg_sel`=0 loads the control bits. Bit 15 drives `ctrl_reset`, bit 14 `link_live`, bit 13 `ctrl_attn`, bit 12 the controller interrupt enable, bit 11 the fault interrupt enable and bit 5 `p2_enable`. Each bit reads back at its position from the next cycle.
- R3: In the control word, bits 10, 7 and 6 read 0. Bit 4 reads `ram_big_strap` and bits [3:0] read `base_strap`. Writes to these bits and to bits 9 and 8 have no effect.
- R4: Control word bit 8 reads the current level of `ctrl_irq`. Bit 9 reads the parity fault flag.
- R5: `board_irq` = (`ctrl_irq` AND enable bit 12) OR (fault flag AND enable bit 11).
- R6: A `par_err` strobe while the flag is clear sets the flag from the next cycle and captures the fault details. Address bits [15:0] read at `reg_sel`=2. Address bits [19:16] read in bits [3:0] at `reg_sel`=1. `par_src` reads in bit 7 and `par_end` in bit 6 of `reg_sel`=1.
- R7: While the flag is set, further `par_err` strobes change neither the flag nor any captured field.
- R8: A write with `reg_sel`=1 and bit 8 set clears the flag and all captured fields from the next cycle. This takes priority over a `par_err` in the same cycle. Bit 8 always reads 0, and a write to `reg_sel`=1 with bit 8 clear has no effect.
- R9: `reg_sel`=3 reads 0. Writes to `reg_sel`=2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 fault detail, 2 fault address low, 3 none |
| wr_en | input | 1 | Write strobe, committed at the rising edge |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Selected register contents |
| base_strap | input | 4 | Upper RAM base address strap (address bits 17–20) |
| ram_big_strap | input | 1 | Strap set when larger RAM devices are fitted |
| ctrl_irq | input | 1 | Interrupt request from the controller chip |
| par_err | input | 1 | One-cycle parity error strobe from the RAM checker |
| par_addr | input | 20 | Failing address, valid with `par_err` |
| par_src | input | 1 | Error source, valid with `par_err` |
| par_end | input | 1 | Failing byte end, valid with `par_err` |
| ctrl_reset | output | 1 | Reset to the controller chip |
| ctrl_attn | output | 1 | Attention line to the controller chip |
| link_live | output | 1 | High takes the link out of loopback |
| p2_enable | output | 1 | Auxiliary bus enable |
| board_irq | output | 1 | Combined board interrupt |

## Verification
The assertions assume that `par_addr`, `par_src` and `par_end` are valid in any cycle where `par_err` is high. They also assume that the straps and `ctrl_irq` are driven to known levels once reset is released. The stimulus changes every input on the falling edge, pulses `par_err` for exactly one cycle with a fully defined address, and holds the straps steady across each read. This keeps capture timing and read data unambiguous.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int REG_W = 16;

    // Register select codes
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_FAULT = 2'd1,
        SEL_FADDR = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // Parity capture states
    typedef enum logic [0:0] {
        CAP_IDLE = 1'b0,
        CAP_HELD = 1'b1
    } cap_state_e;

    // Control word bit positions (software decodes these)
    localparam int B_RESET  = 15;
    localparam int B_LIVE   = 14;
    localparam int B_ATTN   = 13;
    localparam int B_IEN    = 12;
    localparam int B_PIEN   = 11;
    localparam int B_PFLAG  = 9;
    localparam int B_IRQ    = 8;
    localparam int B_P2     = 5;
    localparam int B_BIGRAM = 4;
    localparam int STRAP_W  = 4;

    // Fault detail word bit positions
    localparam int F_ACK = 8;
    localparam int F_SRC = 7;
    localparam int F_END = 6;

    typedef struct packed {
        logic brd_reset;
        logic live;
        logic attn;
        logic irq_en;
        logic perr_en;
        logic p2en;
    } ctl_bits_t;

endpackage

// File: rtl/bcs_ctl_reg.sv
module bcs_ctl_reg
    import bcs_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    output ctl_bits_t     ctl
);

    ctl_bits_t ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ctrl) begin
            ctl_q.brd_reset <= wdata[B_RESET];
            ctl_q.live      <= wdata[B_LIVE];
            ctl_q.attn      <= wdata[B_ATTN];
            ctl_q.irq_en    <= wdata[B_IEN];
            ctl_q.perr_en   <= wdata[B_PIEN];
            ctl_q.p2en      <= wdata[B_P2];
        end
    end

    assign ctl = ctl_q;

    // R2
    ctl_reset_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctl.brd_reset == $past(wdata[B_RESET])));

    // R2
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctl));

endmodule

// File: rtl/bcs_par_capture.sv
module bcs_par_capture
    import bcs_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          err_stb,
    input  logic [AW-1:0] err_addr,
    input  logic          err_src,
    input  logic          err_end,
    input  logic          ack,
    output logic          flag,
    output logic [AW-1:0] held_addr,
    output logic          held_src,
    output logic          held_end
);

    cap_state_e state_q, state_d;
    logic          load, clear;
    logic [AW-1:0] addr_q;
    logic          src_q, end_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    // Next state and datapath controls
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        clear   = 1'b0;
        unique case (state_q)
            CAP_IDLE: begin
                if (ack) begin
                    clear = 1'b1;
                end else if (err_stb) begin
                    load    = 1'b1;
                    state_d = CAP_HELD;
                end
            end
            CAP_HELD: begin
                if (ack) begin
                    clear   = 1'b1;
                    state_d = CAP_IDLE;
                end
            end
            default: state_d = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            src_q  <= 1'b0;
            end_q  <= 1'b0;
        end else if (clear) begin
            addr_q <= '0;
            src_q  <= 1'b0;
            end_q  <= 1'b0;
        end else if (load) begin
            addr_q <= err_addr;
            src_q  <= err_src;
            end_q  <= err_end;
        end
    end

    assign flag      = (state_q == CAP_HELD);
    assign held_addr = addr_q;
    assign held_src  = src_q;
    assign held_end  = end_q;

    // R6
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && err_stb && !ack) |=> (flag && held_addr == $past(err_addr)));

    // R7
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ack) |=> (flag && $stable(held_addr) && $stable(held_src) && $stable(held_end)));

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!flag && held_addr == '0 && !held_src && !held_end));

endmodule

// File: rtl/bcs_read_mux.sv
module bcs_read_mux
    import bcs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = REG_W
) (
    input  logic [1:0]         sel,
    input  ctl_bits_t          ctl,
    input  logic               flag,
    input  logic               irq_lvl,
    input  logic               big_ram,
    input  logic [STRAP_W-1:0] strap,
    input  logic [AW-1:0]      held_addr,
    input  logic               held_src,
    input  logic               held_end,
    output logic [DW-1:0]      rdata
);

    localparam int HI_W = AW - DW;

    logic [DW-1:0] ctrl_word, fault_word, faddr_word;

    always_comb begin
        ctrl_word                 = '0;
        ctrl_word[B_RESET]        = ctl.brd_reset;
        ctrl_word[B_LIVE]         = ctl.live;
        ctrl_word[B_ATTN]         = ctl.attn;
        ctrl_word[B_IEN]          = ctl.irq_en;
        ctrl_word[B_PIEN]         = ctl.perr_en;
        ctrl_word[B_PFLAG]        = flag;
        ctrl_word[B_IRQ]          = irq_lvl;
        ctrl_word[B_P2]           = ctl.p2en;
        ctrl_word[B_BIGRAM]       = big_ram;
        ctrl_word[STRAP_W-1:0]    = strap;

        fault_word                = '0;
        fault_word[F_SRC]         = held_src;
        fault_word[F_END]         = held_end;
        fault_word[HI_W-1:0]      = held_addr[AW-1:DW];

        faddr_word                = held_addr[DW-1:0];
    end

    always_comb begin
        unique case (reg_sel_e'(sel))
            SEL_CTRL:  rdata = ctrl_word;
            SEL_FAULT: rdata = fault_word;
            SEL_FADDR: rdata = faddr_word;
            SEL_NONE:  rdata = '0;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/bcs_board_ctl.sv
module bcs_board_ctl
    import bcs_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          reg_sel,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    rdata,
    input  logic [STRAP_W-1:0]  base_strap,
    input  logic                ram_big_strap,
    input  logic                ctrl_irq,
    input  logic                par_err,
    input  logic [AW-1:0]       par_addr,
    input  logic                par_src,
    input  logic                par_end,
    output logic                ctrl_reset,
    output logic                ctrl_attn,
    output logic                link_live,
    output logic                p2_enable,
    output logic                board_irq
);

    ctl_bits_t     ctl;
    logic          wr_ctrl, ack;
    logic          flag;
    logic [AW-1:0] held_addr;
    logic          held_src, held_end;

    assign wr_ctrl = wr_en && (reg_sel == SEL_CTRL);
    assign ack     = wr_en && (reg_sel == SEL_FAULT) && wdata[F_ACK];

    bcs_ctl_reg #(.DW(REG_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wdata   (wdata),
        .ctl     (ctl)
    );

    bcs_par_capture #(.AW(AW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_stb   (par_err),
        .err_addr  (par_addr),
        .err_src   (par_src),
        .err_end   (par_end),
        .ack       (ack),
        .flag      (flag),
        .held_addr (held_addr),
        .held_src  (held_src),
        .held_end  (held_end)
    );

    bcs_read_mux #(.AW(AW), .DW(REG_W)) u_mux (
        .sel       (reg_sel),
        .ctl       (ctl),
        .flag      (flag),
        .irq_lvl   (ctrl_irq),
        .big_ram   (ram_big_strap),
        .strap     (base_strap),
        .held_addr (held_addr),
        .held_src  (held_src),
        .held_end  (held_end),
        .rdata     (rdata)
    );

    assign ctrl_reset = ctl.brd_reset;
    assign ctrl_attn  = ctl.attn;
    assign link_live  = ctl.live;
    assign p2_enable  = ctl.p2en;
    assign board_irq  = (ctrl_irq & ctl.irq_en) | (flag & ctl.perr_en);

    // R5
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_irq && !flag) |-> !board_irq);

    // R5
    irq_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ctl.perr_en) |-> board_irq);

    // R9
    faddr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_FADDR && flag && !par_err) |=> $stable(held_addr));

endmodule

// File: tb/bcs_board_ctl_tb.sv
`timescale 1ns/1ps
module bcs_board_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  base_strap = '0;
    logic        ram_big_strap = 1'b0;
    logic        ctrl_irq = 1'b0;
    logic        par_err = 1'b0;
    logic [19:0] par_addr = '0;
    logic        par_src = 1'b0;
    logic        par_end = 1'b0;
    logic        ctrl_reset, ctrl_attn, link_live, p2_enable, board_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bcs_board_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .base_strap(base_strap),
        .ram_big_strap(ram_big_strap), .ctrl_irq(ctrl_irq),
        .par_err(par_err), .par_addr(par_addr), .par_src(par_src),
        .par_end(par_end), .ctrl_reset(ctrl_reset), .ctrl_attn(ctrl_attn),
        .link_live(link_live), .p2_enable(p2_enable), .board_irq(board_irq)
    );

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_sel = sel; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] d);
        reg_sel = sel;
        #1;
        d = rdata;
    endtask

    task automatic perr(input logic [19:0] a, input logic s, input logic e);
        @(negedge clk);
        par_err = 1'b1; par_addr = a; par_src = s; par_end = e;
        @(negedge clk);
        par_err = 1'b0; par_addr = '0; par_src = 1'b0; par_end = 1'b0;
    endtask

    task automatic ack();
        wr(2'd1, 16'h0100);
    endtask

    // Expected fault detail word
    function automatic logic [15:0] fexp(input logic [19:0] a, input logic s, input logic e);
        return (16'(s) << 7) | (16'(e) << 6) | 16'(a[19:16]);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [19:0] addrs [4];
        addrs[0] = 20'hFFFFF; addrs[1] = 20'h00001;
        addrs[2] = 20'hA5C3E; addrs[3] = 20'h5F00F;

        repeat (3) @(negedge clk);
        // R1 reset state
        rd(2'd0, r); check("R1 ctrl word", r, 16'h0000);
        rd(2'd1, r); check("R1 fault word", r, 16'h0000);
        rd(2'd2, r); check("R1 fault addr", r, 16'h0000);
        check("R1 outputs", {ctrl_reset, ctrl_attn, link_live, p2_enable, board_irq}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3 exhaustive sweep over the six writable bits, read-only bits forced to 1
        for (int v = 0; v < 64; v++) begin
            logic [15:0] pat, expw;
            pat = (16'(v[5]) << 15) | (16'(v[4]) << 14) | (16'(v[3]) << 13) |
                  (16'(v[2]) << 12) | (16'(v[1]) << 11) | (16'(v[0]) << 5);
            base_strap = v[3:0];
            ram_big_strap = v[1] ^ v[4];
            wr(2'd0, pat | 16'h07DF);
            expw = pat | (16'(ram_big_strap) << 4) | 16'(base_strap);
            rd(2'd0, r);
            check("R2 R3 ctrl readback", r, expw);
            check("R2 outputs", {ctrl_reset, link_live, ctrl_attn, p2_enable},
                  {v[5], v[4], v[3], v[0]});
        end
        base_strap = 4'h0; ram_big_strap = 1'b0;

        // R4/R5 exhaustive over irq, enables and fault flag
        for (int v = 0; v < 16; v++) begin
            logic ie, pie, fl, irq;
            ie = v[0]; pie = v[1]; fl = v[2]; irq = v[3];
            wr(2'd0, (16'(ie) << 12) | (16'(pie) << 11));
            ack();
            if (fl) perr(20'h12345, 1'b0, 1'b0);
            ctrl_irq = irq;
            rd(2'd0, r);
            check("R4 irq mirror", r[8], irq);
            check("R4 flag bit", r[9], fl);
            check("R5 board_irq", board_irq, (irq & ie) | (fl & pie));
        end
        ctrl_irq = 1'b0;
        wr(2'd0, 16'h0000);
        ack();

        // R6/R7/R8 capture across address patterns
        for (int i = 0; i < 4; i++) begin
            logic [19:0] a;
            a = addrs[i];
            perr(a, i[0], i[1]);
            rd(2'd0, r); check("R6 flag set", r[9], 1'b1);
            rd(2'd1, r); check("R6 fault word", r, fexp(a, i[0], i[1]));
            rd(2'd2, r); check("R6 addr low", r, a[15:0]);
            perr(~a, ~i[0], ~i[1]);
            rd(2'd1, r); check("R7 fault word held", r, fexp(a, i[0], i[1]));
            rd(2'd2, r); check("R7 addr held", r, a[15:0]);
            wr(2'd1, 16'hFEFF);
            rd(2'd0, r); check("R8 no-ack write keeps flag", r[9], 1'b1);
            rd(2'd2, r); check("R8 no-ack write keeps addr", r, a[15:0]);
            wr(2'd2, 16'h0000);
            wr(2'd3, 16'hFFFF);
            rd(2'd2, r); check("R9 addr write ignored", r, a[15:0]);
            rd(2'd3, r); check("R9 sel 3 reads 0", r, 16'h0000);
            ack();
            rd(2'd0, r); check("R8 flag cleared", r[9], 1'b0);
            rd(2'd1, r); check("R8 fault word cleared, ack reads 0", r, 16'h0000);
            rd(2'd2, r); check("R8 addr cleared", r, 16'h0000);
        end

        // R8 ack and error in the same cycle: ack wins
        @(negedge clk);
        reg_sel = 2'd1; wdata = 16'h0100; wr_en = 1'b1;
        par_err = 1'b1; par_addr = 20'hBEEF1; par_src = 1'b1; par_end = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; par_err = 1'b0; par_addr = '0; par_src = 1'b0; par_end = 1'b0;
        rd(2'd0, r); check("R8 ack beats error flag", r[9], 1'b0);
        rd(2'd2, r); check("R8 ack beats error addr", r, 16'h0000);

        // R6 capture after release works again
        perr(20'h3C0DE, 1'b1, 1'b0);
        rd(2'd1, r); check("R6 recapture", r, fexp(20'h3C0DE, 1'b1, 1'b0));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule